// File: doc/BRIEF.md
# Chunk Pool Manager with Multicast Copy Counts

This block keeps the bookkeeping for a packet buffer that is carved into fixed-size chunks. It holds the indices of unused chunks in a first-in first-out free list. A segmentation engine asks for one chunk at a time and gets an index back, or a failure flag when the pool is exhausted. The engine then appends each filled chunk to a reassembly context named by a small identifier. The block links the chunks of that context into a chain through a next-pointer table, which marks the end of a chain with an all-ones value.

When the last chunk of a packet is appended with the end flag, the block reports the packet's first chunk and its length in chunks. It also records how many copies of the packet will be sent. Each release of the packet, named by its first chunk, removes one copy. When the last copy goes, a walker follows the chain and returns one chunk to the free list per clock. It refuses new releases while it is doing so. The packet data memory lives outside; only indices and counts are kept here.

Top module: `chunk_pool_mgr`

## Requirements
- R1: After reset `free_count` equals NCHUNK (64), `alloc_gnt` and `alloc_fail` are low, `rel_ready` is high, and the first allocations hand out indices 0, 1, 2 and so on in ascending order.
- R2: A cycle with `alloc_req` high and a non-empty pool raises `alloc_gnt` for one cycle on the next clock, with `alloc_ptr` holding the oldest free index, and `free_count` drops by one. Indices that are returned go to the back of the free order.
- R3: A request made while `free_count` is 0 raises `alloc_fail` on the next clock, with no grant, and `free_count` stays at 0.
- R4: Appends to different context identifiers may be interleaved; each context builds its own chain in its own append order.
- R5: An append with `app_eop` high raises `done_valid` one clock later, with the context, the first chunk of the packet and its chunk count (a single-chunk packet reports 1), and the context is then free for a new packet.
- R6: A release of a packet whose remaining copy count is above 1 only lowers the count: `free_count` is unchanged and `rel_ready` stays high.
- R7: The release that removes the last copy drops `rel_ready` on the next clock. The chain is then returned in chain order at one chunk per clock, so `free_count` rises by one each cycle, and `rel_ready` returns high once the last chunk is back.
- R8: A release presented while `rel_ready` is low is ignored: that packet keeps its copy count and none of its chunks return to the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Ask for one chunk this cycle |
| alloc_gnt | output | 1 | Chunk granted, index on `alloc_ptr` |
| alloc_fail | output | 1 | Request refused, pool empty |
| alloc_ptr | output | IW (6) | Granted chunk index |
| app_valid | input | 1 | Append a chunk to a context |
| app_ctx | input | CXW (2) | Context identifier of the append |
| app_ptr | input | IW (6) | Chunk index being appended |
| app_eop | input | 1 | This chunk ends the packet |
| app_copies | input | RW (4) | Copy count for the packet, used with `app_eop`, at least 1 |
| done_valid | output | 1 | A packet was completed |
| done_ctx | output | CXW (2) | Context of the completed packet |
| done_head | output | IW (6) | First chunk of the completed packet |
| done_count | output | FW (7) | Chunks in the completed packet |
| rel_valid | input | 1 | Release one copy of a packet |
| rel_head | input | IW (6) | First chunk of the released packet |
| rel_ready | output | 1 | High when a release is accepted |
| free_count | output | FW (7) | Chunks currently in the pool |

## Verification
The hardest state to reach is a release that arrives while the walker is busy returning another chain. The walk lasts only as many cycles as that chain has chunks. The bench builds a two-chunk packet and releases its last copy. It then holds a release of a second packet on the port through every cycle of the walk. It checks that the pool grows by exactly the first chain, and that a later release of the second packet still frees its whole chain. Draining the pool after several chains have been returned checks the free order as the walker produced it. The bench then checks the refusal at zero.

// File: rtl/cpm_pkg.sv
// Shared types for the chunk pool manager.
package cpm_pkg;
    // State of the chain walker that reclaims chunks.
    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } walk_st_t;
endpackage

// File: rtl/cpm_free_fifo.sv
// Free list of chunk indices, kept as a circular FIFO.
// Assumes: at most one pop and one push per cycle; a pushed index is
// never already in the list. A pop uses the count from before this
// cycle's push, so an empty pool refuses even while a push is arriving.
module cpm_free_fifo #(
    parameter int NCHUNK = 64,
    parameter int IW     = $clog2(NCHUNK),
    parameter int FW     = $clog2(NCHUNK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop_req,
    output logic          pop_gnt,
    output logic          pop_fail,
    output logic [IW-1:0] pop_idx,
    input  logic          push_valid,
    input  logic [IW-1:0] push_idx,
    output logic [FW-1:0] count
);
    localparam logic [IW-1:0] LAST = IW'(NCHUNK - 1);

    logic [IW-1:0] slots [NCHUNK];
    logic [IW-1:0] rd_q, wr_q;
    logic          pop_ok;

    // Pop only when the pool holds a chunk.
    assign pop_ok = pop_req && (count != '0);

    // Pointer and slot update; reset loads every index in ascending order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCHUNK; i++) slots[i] <= IW'(i);
            rd_q     <= '0;
            wr_q     <= '0;
            count    <= FW'(NCHUNK);
            pop_gnt  <= 1'b0;
            pop_fail <= 1'b0;
            pop_idx  <= '0;
        end else begin
            pop_gnt  <= pop_ok;
            pop_fail <= pop_req && (count == '0);
            if (pop_ok) begin
                pop_idx <= slots[rd_q];
                rd_q    <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
            end
            if (push_valid) begin
                slots[wr_q] <= push_idx;
                wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
            end
            count <= count + FW'(push_valid) - FW'(pop_ok);
        end
    end

    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FW'(NCHUNK)); // R1
    AST_EMPTY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && count == '0 && !push_valid |=> pop_fail && !pop_gnt && count == '0); // R3
endmodule

// File: rtl/cpm_ctx_link.sv
// Reassembly contexts and the next-pointer table.
// Each context keeps an open flag, its first chunk, its last chunk and a
// chunk count. An append writes the end marker into the new chunk's entry
// and links the previous last chunk to it. An end-of-packet append
// reports the packet one cycle later. The walker reads links through a
// combinational port.
// Assumes: an appended chunk was granted and not appended before.
module cpm_ctx_link #(
    parameter int NCHUNK = 64,
    parameter int NCTX   = 4,
    parameter int RW     = 4,
    parameter int IW     = $clog2(NCHUNK),
    parameter int PW     = IW + 1,
    parameter int FW     = $clog2(NCHUNK + 1),
    parameter int CXW    = $clog2(NCTX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           app_valid,
    input  logic [CXW-1:0] app_ctx,
    input  logic [IW-1:0]  app_ptr,
    input  logic           app_eop,
    input  logic [RW-1:0]  app_copies,
    output logic           done_valid,
    output logic [CXW-1:0] done_ctx,
    output logic [IW-1:0]  done_head,
    output logic [FW-1:0]  done_count,
    output logic [RW-1:0]  done_copies,
    input  logic [IW-1:0]  lk_idx,
    output logic [PW-1:0]  lk_data
);
    localparam logic [PW-1:0] END_MARK = '1;

    logic [PW-1:0] links [NCHUNK];
    logic          open_q [NCTX];
    logic [IW-1:0] head_q [NCTX];
    logic [IW-1:0] tail_q [NCTX];
    logic [FW-1:0] cnt_q  [NCTX];
    logic [IW-1:0] head_n;
    logic [FW-1:0] cnt_n;

    // Read port for the walker.
    assign lk_data = links[lk_idx];

    // Head and length the context will hold after this append.
    always_comb begin
        head_n = open_q[app_ctx] ? head_q[app_ctx] : app_ptr;
        cnt_n  = open_q[app_ctx] ? cnt_q[app_ctx] + 1'b1 : FW'(1);
    end

    // Context state, chain links and the completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCHUNK; i++) links[i] <= END_MARK;
            for (int c = 0; c < NCTX; c++) begin
                open_q[c] <= 1'b0;
                head_q[c] <= '0;
                tail_q[c] <= '0;
                cnt_q[c]  <= '0;
            end
            done_valid  <= 1'b0;
            done_ctx    <= '0;
            done_head   <= '0;
            done_count  <= '0;
            done_copies <= '0;
        end else begin
            done_valid <= 1'b0;
            if (app_valid) begin
                links[app_ptr] <= END_MARK;
                if (open_q[app_ctx]) links[tail_q[app_ctx]] <= PW'(app_ptr);
                head_q[app_ctx] <= head_n;
                tail_q[app_ctx] <= app_ptr;
                cnt_q[app_ctx]  <= cnt_n;
                open_q[app_ctx] <= !app_eop;
                if (app_eop) begin
                    done_valid  <= 1'b1;
                    done_ctx    <= app_ctx;
                    done_head   <= head_n;
                    done_count  <= cnt_n;
                    done_copies <= app_copies;
                end
            end
        end
    end

    AST_FRESH_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        app_valid && open_q[app_ctx] |-> tail_q[app_ctx] != app_ptr); // R4
    AST_DONE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_count != '0 && done_copies != '0); // R5
endmodule

// File: rtl/cpm_reclaim.sv
// Copy counts and the chain walker.
// A completed packet stores its copy count under its first chunk. Each
// accepted release lowers it. The release that removes the last copy
// starts a walk that pushes one chunk per cycle to the free list,
// following the links until the end marker. Releases are refused while
// walking.
// Assumes: a released packet was completed and still has copies left.
module cpm_reclaim #(
    parameter int NCHUNK = 64,
    parameter int RW     = 4,
    parameter int IW     = $clog2(NCHUNK),
    parameter int PW     = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_valid,
    input  logic [IW-1:0] done_head,
    input  logic [RW-1:0] done_copies,
    input  logic          rel_valid,
    input  logic [IW-1:0] rel_head,
    output logic          rel_ready,
    output logic [IW-1:0] lk_idx,
    input  logic [PW-1:0] lk_data,
    output logic          push_valid,
    output logic [IW-1:0] push_idx
);
    import cpm_pkg::*;

    localparam logic [PW-1:0] END_MARK = '1;

    logic [RW-1:0] copies_q [NCHUNK];
    walk_st_t      st_q;
    logic [IW-1:0] wptr_q;

    // Walker outputs: the current chunk is both pushed and looked up.
    assign rel_ready  = (st_q == WK_IDLE);
    assign push_valid = (st_q == WK_RUN);
    assign push_idx   = wptr_q;
    assign lk_idx     = wptr_q;

    // Copy-count updates and walker stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCHUNK; i++) copies_q[i] <= '0;
            st_q   <= WK_IDLE;
            wptr_q <= '0;
        end else begin
            if (done_valid) copies_q[done_head] <= done_copies;
            if (st_q == WK_IDLE) begin
                if (rel_valid) begin
                    if (copies_q[rel_head] <= RW'(1)) begin
                        copies_q[rel_head] <= '0;
                        st_q   <= WK_RUN;
                        wptr_q <= rel_head;
                    end else begin
                        copies_q[rel_head] <= copies_q[rel_head] - 1'b1;
                    end
                end
            end else begin
                if (lk_data == END_MARK) st_q <= WK_IDLE;
                else wptr_q <= lk_data[IW-1:0];
            end
        end
    end

    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && rel_ready |-> copies_q[rel_head] != '0); // R6
    AST_BUSY_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && !rel_ready && !done_valid |=> copies_q[$past(rel_head)] == $past(copies_q[rel_head])); // R8
endmodule

// File: rtl/chunk_pool_mgr.sv
// Chunk pool manager: free list, per-context chaining and per-packet copy
// counts for a chunked packet buffer.
// Assumes: the caller appends only granted chunks, releases only
// completed packets, and gives a copy count of at least 1 at end of packet.
module chunk_pool_mgr #(
    parameter int NCHUNK = 64,
    parameter int NCTX   = 4,
    parameter int RW     = 4,
    localparam int IW    = $clog2(NCHUNK),
    localparam int PW    = IW + 1,
    localparam int FW    = $clog2(NCHUNK + 1),
    localparam int CXW   = $clog2(NCTX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_req,
    output logic           alloc_gnt,
    output logic           alloc_fail,
    output logic [IW-1:0]  alloc_ptr,
    input  logic           app_valid,
    input  logic [CXW-1:0] app_ctx,
    input  logic [IW-1:0]  app_ptr,
    input  logic           app_eop,
    input  logic [RW-1:0]  app_copies,
    output logic           done_valid,
    output logic [CXW-1:0] done_ctx,
    output logic [IW-1:0]  done_head,
    output logic [FW-1:0]  done_count,
    input  logic           rel_valid,
    input  logic [IW-1:0]  rel_head,
    output logic           rel_ready,
    output logic [FW-1:0]  free_count
);
    logic          push_valid;
    logic [IW-1:0] push_idx;
    logic [IW-1:0] lk_idx;
    logic [PW-1:0] lk_data;
    logic [RW-1:0] done_copies;

    cpm_free_fifo #(.NCHUNK(NCHUNK), .IW(IW), .FW(FW)) u_free (
        .clk(clk), .rst_n(rst_n),
        .pop_req(alloc_req), .pop_gnt(alloc_gnt), .pop_fail(alloc_fail),
        .pop_idx(alloc_ptr),
        .push_valid(push_valid), .push_idx(push_idx),
        .count(free_count)
    );

    cpm_ctx_link #(.NCHUNK(NCHUNK), .NCTX(NCTX), .RW(RW), .IW(IW), .PW(PW),
                   .FW(FW), .CXW(CXW)) u_link (
        .clk(clk), .rst_n(rst_n),
        .app_valid(app_valid), .app_ctx(app_ctx), .app_ptr(app_ptr),
        .app_eop(app_eop), .app_copies(app_copies),
        .done_valid(done_valid), .done_ctx(done_ctx), .done_head(done_head),
        .done_count(done_count), .done_copies(done_copies),
        .lk_idx(lk_idx), .lk_data(lk_data)
    );

    cpm_reclaim #(.NCHUNK(NCHUNK), .RW(RW), .IW(IW), .PW(PW)) u_reclaim (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_head(done_head), .done_copies(done_copies),
        .rel_valid(rel_valid), .rel_head(rel_head), .rel_ready(rel_ready),
        .lk_idx(lk_idx), .lk_data(lk_data),
        .push_valid(push_valid), .push_idx(push_idx)
    );

    AST_WALK_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_ready && !alloc_req |=> free_count == $past(free_count) + 1'b1); // R7
    AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req && free_count != '0 && rel_ready |=> alloc_gnt && free_count == $past(free_count) - 1'b1); // R2
endmodule

// File: tb/tb_chunk_pool_mgr.sv
// Scoreboard bench: driver tasks queue expected grants and completions,
// a monitor on the falling edge pops and compares them.
module tb_chunk_pool_mgr;
    localparam int NCHUNK = 64;
    localparam int NCTX   = 4;
    localparam int RW     = 4;
    localparam int IW     = $clog2(NCHUNK);
    localparam int FW     = $clog2(NCHUNK + 1);
    localparam int CXW    = $clog2(NCTX);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           alloc_req = 1'b0;
    logic           alloc_gnt, alloc_fail;
    logic [IW-1:0]  alloc_ptr;
    logic           app_valid = 1'b0;
    logic [CXW-1:0] app_ctx = '0;
    logic [IW-1:0]  app_ptr = '0;
    logic           app_eop = 1'b0;
    logic [RW-1:0]  app_copies = '0;
    logic           done_valid;
    logic [CXW-1:0] done_ctx;
    logic [IW-1:0]  done_head;
    logic [FW-1:0]  done_count;
    logic           rel_valid = 1'b0;
    logic [IW-1:0]  rel_head = '0;
    logic           rel_ready;
    logic [FW-1:0]  free_count;

    chunk_pool_mgr #(.NCHUNK(NCHUNK), .NCTX(NCTX), .RW(RW)) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_fail(alloc_fail),
        .alloc_ptr(alloc_ptr),
        .app_valid(app_valid), .app_ctx(app_ctx), .app_ptr(app_ptr),
        .app_eop(app_eop), .app_copies(app_copies),
        .done_valid(done_valid), .done_ctx(done_ctx), .done_head(done_head),
        .done_count(done_count),
        .rel_valid(rel_valid), .rel_head(rel_head), .rel_ready(rel_ready),
        .free_count(free_count)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Bench model of the pool and of packets.
    int model_free[$];
    int exp_alloc[$];                 // -1 stands for a refusal
    int exp_dctx[$], exp_dhead[$], exp_dcnt[$];
    int cur_chain[NCTX][NCHUNK];
    int cur_len[NCTX];
    int pk_chain[NCHUNK][NCHUNK];
    int pk_len[NCHUNK];
    int pk_copies[NCHUNK];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare grants/refusals and completions as they appear.
    always @(negedge clk) begin
        if (rst_n && (alloc_gnt || alloc_fail)) begin
            int e, a;
            a = alloc_fail ? -1 : int'(alloc_ptr);
            e = (exp_alloc.size() > 0) ? exp_alloc.pop_front() : -2;
            check(a == e && !(alloc_gnt && alloc_fail), "R2/R3 alloc", a, e);
        end
        if (rst_n && done_valid) begin
            int ec, eh, en;
            ec = (exp_dctx.size() > 0) ? exp_dctx.pop_front() : -1;
            eh = (exp_dhead.size() > 0) ? exp_dhead.pop_front() : -1;
            en = (exp_dcnt.size() > 0) ? exp_dcnt.pop_front() : -1;
            check(int'(done_ctx) == ec, "R5 done ctx", int'(done_ctx), ec);
            check(int'(done_head) == eh, "R4/R5 done head", int'(done_head), eh);
            check(int'(done_count) == en, "R5 done count", int'(done_count), en);
        end
    end

    // Driver: request one chunk, queue the expected outcome.
    task automatic do_alloc(output int p);
        alloc_req = 1'b1;
        if (model_free.size() > 0) p = model_free.pop_front();
        else p = -1;
        exp_alloc.push_back(p);
        @(negedge clk);
        alloc_req = 1'b0;
        check(int'(free_count) == model_free.size(), "R2/R3 free_count", int'(free_count), model_free.size());
    endtask

    // Driver: append one chunk to a context.
    task automatic do_append(input int ctx, input int p, input bit eop, input int copies);
        app_valid  = 1'b1;
        app_ctx    = CXW'(ctx);
        app_ptr    = IW'(p);
        app_eop    = eop;
        app_copies = RW'(copies);
        cur_chain[ctx][cur_len[ctx]] = p;
        cur_len[ctx]++;
        if (eop) begin
            int h;
            h = cur_chain[ctx][0];
            pk_len[h] = cur_len[ctx];
            pk_copies[h] = copies;
            for (int i = 0; i < cur_len[ctx]; i++) pk_chain[h][i] = cur_chain[ctx][i];
            exp_dctx.push_back(ctx);
            exp_dhead.push_back(h);
            exp_dcnt.push_back(cur_len[ctx]);
            cur_len[ctx] = 0;
        end
        @(negedge clk);
        app_valid = 1'b0;
        app_eop   = 1'b0;
    endtask

    // Driver: release one copy; follow a walk cycle by cycle when it starts.
    task automatic do_release(input int h);
        int f0;
        f0 = int'(free_count);
        rel_valid = 1'b1;
        rel_head  = IW'(h);
        @(negedge clk);
        rel_valid = 1'b0;
        pk_copies[h]--;
        if (pk_copies[h] > 0) begin
            check(int'(free_count) == f0, "R6 count kept", int'(free_count), f0);
            check(rel_ready == 1'b1, "R6 ready kept", int'(rel_ready), 1);
        end else begin
            check(rel_ready == 1'b0, "R7 ready drops", int'(rel_ready), 0);
            for (int j = 1; j <= pk_len[h]; j++) begin
                @(negedge clk);
                check(int'(free_count) == f0 + j, "R7 one per cycle", int'(free_count), f0 + j);
            end
            for (int j = 0; j < pk_len[h]; j++) model_free.push_back(pk_chain[h][j]);
            check(rel_ready == 1'b1, "R7 ready returns", int'(rel_ready), 1);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int a, b, c, d, e, f, g, h, p, f0;
        for (int i = 0; i < NCHUNK; i++) model_free.push_back(i);
        for (int i = 0; i < NCTX; i++) cur_len[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(int'(free_count) == NCHUNK, "R1 free_count", int'(free_count), NCHUNK);
        check(!alloc_gnt && !alloc_fail, "R1 no grant", int'(alloc_gnt), 0);
        check(rel_ready == 1'b1, "R1 ready", int'(rel_ready), 1);

        // R1/R2: ascending indices; R5: three-chunk packet, two copies
        do_alloc(a); do_alloc(b); do_alloc(c);
        do_append(0, a, 1'b0, 0);
        do_append(0, b, 1'b0, 0);
        do_append(0, c, 1'b1, 2);

        // R4: interleaved contexts 1 and 2
        do_alloc(d); do_alloc(e);
        do_append(1, d, 1'b0, 0);
        do_append(2, e, 1'b0, 0);
        do_alloc(f);
        do_append(1, f, 1'b1, 1);
        do_alloc(g);
        do_append(2, g, 1'b1, 1);

        // R5: single-chunk packet with three copies
        do_alloc(h);
        do_append(3, h, 1'b1, 3);
        @(negedge clk);

        // R6 then R7 on the first packet
        do_release(a);
        do_release(a);

        // R8: release of packet e held on the port during the walk of d
        f0 = int'(free_count);
        rel_valid = 1'b1;
        rel_head  = IW'(d);
        @(negedge clk);
        pk_copies[d]--;
        rel_head = IW'(e);
        for (int j = 1; j <= pk_len[d]; j++) begin
            @(negedge clk);
            check(int'(free_count) == f0 + j, "R7 walk during busy", int'(free_count), f0 + j);
        end
        rel_valid = 1'b0;
        for (int j = 0; j < pk_len[d]; j++) model_free.push_back(pk_chain[d][j]);
        @(negedge clk);
        check(int'(free_count) == f0 + pk_len[d], "R8 busy release ignored", int'(free_count), f0 + pk_len[d]);
        do_release(e);   // still one copy: full walk proves it was ignored (R8)

        // R6 twice, then R7 with a one-chunk chain
        do_release(h);
        do_release(h);
        do_release(h);

        // R2: drain the pool in FIFO order, then R3 refusals
        while (model_free.size() > 0) do_alloc(p);
        do_alloc(p);
        check(alloc_fail == 1'b1, "R3 refused", int'(alloc_fail), 1);
        do_alloc(p);
        check(int'(free_count) == 0, "R3 stays empty", int'(free_count), 0);
        @(negedge clk);
        check(exp_alloc.size() == 0 && exp_dhead.size() == 0, "R2/R5 scoreboard drained",
              exp_alloc.size() + exp_dhead.size(), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule